// File: doc/BRIEF.md
# Execute-Stage Operand Bypass Selector

This block decides, for an in-order five-stage integer pipeline, where each of the two ALU source operands in the execute stage comes from. There are three possible sources. The first is the value read from the register file. The second is the result held in the execute/memory pipeline register, which belongs to the instruction one ahead. The third is the result held in the memory/writeback pipeline register, which belongs to the instruction two ahead. The block compares the two source register numbers of the instruction in execute with the destination numbers and write enables of the two older instructions. It drives a 2-bit select for each operand mux.

A second output serves a store that sits in the memory stage. When the instruction just ahead of that store is a load whose destination is the store's data register, the selector flags that the store's write data must be taken from the memory/writeback result, not from the value the store carried along.

All outputs are purely combinational. The block has no clock and no state. The operand muxes, the register file and the stall logic live outside it. Because only control selects flow through it, every pin is a plain level signal with no handshake.

Top module: `opnd_bypass_ctrl`

## Requirements
- R1: Each operand select uses three codes. 2'b10 picks the execute/memory result, 2'b01 picks the memory/writeback result, and 2'b00 picks the register file value. The code 2'b11 never appears.
- R2: Operand A select is 2'b10 whenever the execute/memory write enable is 1, its destination is nonzero, and that destination equals the execute-stage first source (rs).
- R3: Operand B select is 2'b10 under the same test as R2, applied to the second source (rt).
- R4: An operand select is 2'b01 when the memory/writeback write enable is 1, its destination is nonzero and equals that operand's source, and R2/R3 does not already pick 2'b10 for that operand.
- R5: When both older instructions write the operand's register, the younger one wins and the select is 2'b10. For example, with three chained writes to r1, the third instruction receives the second instruction's result.
- R6: A destination of register 0 never causes forwarding on any output, whatever the write enables are.
- R7: If an operand meets neither the R2/R3 test nor the R4 test, its select is 2'b00. This includes the case where the register numbers match but the write enable is 0.
- R8: The store-data bypass output is 1 exactly when all four of these hold: the memory/writeback write enable is 1, the memory-stage store flag is 1, the memory/writeback destination equals the store's rt, and that destination is nonzero.
- R9: Outputs follow the inputs in the same cycle, with no register on the path.

Verification approach: constrained random with a fixed seed, plus directed corner cases, checked against bench reference functions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ex_rs_i | input | 5 | First source register of the instruction in execute |
| ex_rt_i | input | 5 | Second source register of the instruction in execute |
| xm_wr_en_i | input | 1 | Register-write enable held in execute/memory |
| xm_rd_i | input | 5 | Destination register held in execute/memory |
| xm_store_i | input | 1 | Memory-write flag of the instruction in the memory stage |
| xm_rt_i | input | 5 | Data-source register of the store in the memory stage |
| mw_wr_en_i | input | 1 | Register-write enable held in memory/writeback |
| mw_rd_i | input | 5 | Destination register held in memory/writeback |
| sel_a_o | output | 2 | Operand A mux select (R1 encoding) |
| sel_b_o | output | 2 | Operand B mux select (R1 encoding) |
| st_bypass_o | output | 1 | Store write data taken from memory/writeback |

## Verification
The checks assume that every input is a known 0 or 1. The immediate checks are skipped while any input is unknown, which is the state before the bench first drives the pins. The bench drives every pin with a defined value at each step. To make matches and register-0 cases common, it draws register numbers from a small set of values {0, 1, 2, 3, 31}, and it toggles the enables at random, so that every priority combination comes up many times.

// File: rtl/opnd_bypass_pkg.sv
package opnd_bypass_pkg;
  parameter int REG_AW = 5;
  parameter int NUM_SRC = 2;

  typedef logic [REG_AW-1:0] reg_idx_t;

  typedef enum logic [1:0] {
    SRC_REGFILE = 2'b00,
    SRC_MEMWB   = 2'b01,
    SRC_EXMEM   = 2'b10
  } src_sel_e;
endpackage

// File: rtl/bypass_hit.sv
// One producer/consumer comparison: a live, nonzero destination equal to the source.
module bypass_hit #(
  parameter int AW = 5
) (
  input  logic          wr_en_i,
  input  logic [AW-1:0] dst_i,
  input  logic [AW-1:0] src_i,
  output logic          hit_o
);
  logic dst_live;
  assign dst_live = wr_en_i && (dst_i != '0);
  assign hit_o    = dst_live && (dst_i == src_i);
endmodule

// File: rtl/bypass_prio.sv
// Encodes two hit flags into a mux select; the younger stage takes precedence.
module bypass_prio
  import opnd_bypass_pkg::*;
(
  input  logic       near_hit_i,
  input  logic       far_hit_i,
  output logic [1:0] sel_o
);
  src_sel_e sel;
  always_comb begin
    if (near_hit_i)     sel = SRC_EXMEM;
    else if (far_hit_i) sel = SRC_MEMWB;
    else                sel = SRC_REGFILE;
  end
  assign sel_o = sel;
endmodule

// File: rtl/opnd_bypass_ctrl.sv
module opnd_bypass_ctrl
  import opnd_bypass_pkg::*;
#(
  parameter int AW = REG_AW
) (
  input  logic [AW-1:0] ex_rs_i,
  input  logic [AW-1:0] ex_rt_i,
  input  logic          xm_wr_en_i,
  input  logic [AW-1:0] xm_rd_i,
  input  logic          xm_store_i,
  input  logic [AW-1:0] xm_rt_i,
  input  logic          mw_wr_en_i,
  input  logic [AW-1:0] mw_rd_i,
  output logic [1:0]    sel_a_o,
  output logic [1:0]    sel_b_o,
  output logic          st_bypass_o
);
  localparam int NSRC = NUM_SRC;

  logic [NSRC-1:0][AW-1:0] src;
  logic [NSRC-1:0][1:0]    sel;

  assign src[0] = ex_rs_i;
  assign src[1] = ex_rt_i;

  // One comparator pair and one priority encoder per execute-stage source.
  for (genvar g = 0; g < NSRC; g++) begin : g_src
    logic near_hit, far_hit;

    bypass_hit #(.AW(AW)) u_near (
      .wr_en_i (xm_wr_en_i),
      .dst_i   (xm_rd_i),
      .src_i   (src[g]),
      .hit_o   (near_hit)
    );

    bypass_hit #(.AW(AW)) u_far (
      .wr_en_i (mw_wr_en_i),
      .dst_i   (mw_rd_i),
      .src_i   (src[g]),
      .hit_o   (far_hit)
    );

    bypass_prio u_prio (
      .near_hit_i (near_hit),
      .far_hit_i  (far_hit),
      .sel_o      (sel[g])
    );
  end

  assign sel_a_o = sel[0];
  assign sel_b_o = sel[1];

  // Load result in memory/writeback feeding the store now in the memory stage.
  bypass_hit #(.AW(AW)) u_store (
    .wr_en_i (mw_wr_en_i && xm_store_i),
    .dst_i   (mw_rd_i),
    .src_i   (xm_rt_i),
    .hit_o   (st_bypass_o)
  );
endmodule

// File: rtl/opnd_bypass_chk.sv
module opnd_bypass_chk #(
  parameter int AW = 5
) (
  input logic [AW-1:0] ex_rs_i,
  input logic [AW-1:0] ex_rt_i,
  input logic          xm_wr_en_i,
  input logic [AW-1:0] xm_rd_i,
  input logic          xm_store_i,
  input logic [AW-1:0] xm_rt_i,
  input logic          mw_wr_en_i,
  input logic [AW-1:0] mw_rd_i,
  input logic [1:0]    sel_a_o,
  input logic [1:0]    sel_b_o,
  input logic          st_bypass_o
);
  logic known;
  assign known = !$isunknown({ex_rs_i, ex_rt_i, xm_wr_en_i, xm_rd_i, xm_store_i,
                              xm_rt_i, mw_wr_en_i, mw_rd_i});

  always_comb begin
    if (known) begin
      a_r1_no_code3: assert (sel_a_o != 2'b11 && sel_b_o != 2'b11);
      // An execute/memory pick needs a live, nonzero, matching producer.
      a_r2_exmem_a: assert (sel_a_o != 2'b10 ||
                            (xm_wr_en_i && xm_rd_i == ex_rs_i && xm_rd_i != '0));
      a_r3_exmem_b: assert (sel_b_o != 2'b10 ||
                            (xm_wr_en_i && xm_rd_i == ex_rt_i && xm_rd_i != '0));
      // A memory/writeback pick means the younger stage did not qualify.
      a_r5_young_wins: assert (sel_a_o != 2'b01 ||
                               !(xm_wr_en_i && xm_rd_i == ex_rs_i && xm_rd_i != '0));
      a_r4_memwb_a: assert (sel_a_o != 2'b01 ||
                            (mw_wr_en_i && mw_rd_i == ex_rs_i && mw_rd_i != '0));
      a_r6_zero_never: assert (ex_rs_i != '0 || sel_a_o == 2'b00);
      a_r8_store_bypass: assert (!st_bypass_o ||
                                 (xm_store_i && mw_wr_en_i && mw_rd_i == xm_rt_i));
      a_r7_idle: assert ((xm_wr_en_i || mw_wr_en_i) ||
                         (sel_a_o == 2'b00 && sel_b_o == 2'b00 && !st_bypass_o));
    end
  end
endmodule

bind opnd_bypass_ctrl opnd_bypass_chk #(.AW(AW)) i_chk (
  .ex_rs_i     (ex_rs_i),
  .ex_rt_i     (ex_rt_i),
  .xm_wr_en_i  (xm_wr_en_i),
  .xm_rd_i     (xm_rd_i),
  .xm_store_i  (xm_store_i),
  .xm_rt_i     (xm_rt_i),
  .mw_wr_en_i  (mw_wr_en_i),
  .mw_rd_i     (mw_rd_i),
  .sel_a_o     (sel_a_o),
  .sel_b_o     (sel_b_o),
  .st_bypass_o (st_bypass_o)
);

// File: tb/test_opnd_bypass_ctrl.sv
`timescale 1ns/1ps
module test_opnd_bypass_ctrl;
  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [4:0] rs, rt, xrd, xrt, mrd;
  logic       xwe, xst, mwe;
  logic [1:0] sa, sb;
  logic       stb;
  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  opnd_bypass_ctrl i_opnd_bypass_ctrl (
    .ex_rs_i(rs), .ex_rt_i(rt), .xm_wr_en_i(xwe), .xm_rd_i(xrd),
    .xm_store_i(xst), .xm_rt_i(xrt), .mw_wr_en_i(mwe), .mw_rd_i(mrd),
    .sel_a_o(sa), .sel_b_o(sb), .st_bypass_o(stb)
  );

  function automatic logic [1:0] ref_sel(logic [4:0] s, logic xw, logic [4:0] xd,
                                         logic mw, logic [4:0] md);
    if (xw && xd != 0 && xd == s) return 2'b10;
    if (mw && md != 0 && md == s) return 2'b01;
    return 2'b00;
  endfunction

  function automatic logic ref_st(logic mw, logic xs, logic [4:0] md, logic [4:0] t);
    return mw && xs && md != 0 && md == t;
  endfunction

  task automatic chk(string tag, logic [1:0] act, logic [1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic apply(logic [4:0] a, logic [4:0] b, logic xw, logic [4:0] xd,
                       logic xs, logic [4:0] xt, logic mw, logic [4:0] md);
    @(negedge clk);
    rs = a; rt = b; xwe = xw; xrd = xd; xst = xs; xrt = xt; mwe = mw; mrd = md;
    #0.5;  // R9: combinational, settles within the same cycle
  endtask

  task automatic check_all(string tag);
    chk({tag, " R2 sel_a"}, sa, ref_sel(rs, xwe, xrd, mwe, mrd));
    chk({tag, " R3 sel_b"}, sb, ref_sel(rt, xwe, xrd, mwe, mrd));
    chk({tag, " R8 store"}, {1'b0, stb}, {1'b0, ref_st(mwe, xst, mrd, xrt)});
  endtask

  function automatic logic [4:0] pick_reg();
    case ($urandom % 5)
      0: return 5'd0;
      1: return 5'd1;
      2: return 5'd2;
      3: return 5'd3;
      default: return 5'd31;
    endcase
  endfunction

  initial begin
    #100000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    // Idle: nothing writes
    apply(0, 0, 0, 0, 0, 0, 0, 0);
    chk("R7 idle sel_a", sa, 2'b00);
    chk("R7 idle sel_b", sb, 2'b00);
    chk("R7 idle store", {1'b0, stb}, 2'b00);
    // R2 / R3: execute/memory match on each operand
    apply(5, 6, 1, 5, 0, 0, 0, 0);
    chk("R2 exmem to A", sa, 2'b10);
    chk("R1 B untouched", sb, 2'b00);
    apply(5, 6, 1, 6, 0, 0, 0, 0);
    chk("R3 exmem to B", sb, 2'b10);
    // R4: memory/writeback only
    apply(7, 7, 0, 0, 0, 0, 1, 7);
    chk("R4 memwb to A", sa, 2'b01);
    chk("R4 memwb to B", sb, 2'b01);
    // R5: three chained writes to r1, third reads r1
    apply(1, 1, 1, 1, 0, 0, 1, 1);
    chk("R5 chain A", sa, 2'b10);
    chk("R5 chain B", sb, 2'b10);
    // R5: younger matches but does not write -> older result used
    apply(4, 9, 0, 4, 0, 0, 1, 4);
    chk("R5 near idle A", sa, 2'b01);
    // R6: register 0
    apply(0, 0, 1, 0, 1, 0, 1, 0);
    chk("R6 zero A", sa, 2'b00);
    chk("R6 zero B", sb, 2'b00);
    chk("R6 zero store", {1'b0, stb}, 2'b00);
    // R7: numbers match, enables low
    apply(8, 8, 0, 8, 1, 8, 0, 8);
    chk("R7 no enable A", sa, 2'b00);
    chk("R7 no enable store", {1'b0, stb}, 2'b00);
    // R8: load then store
    apply(2, 3, 0, 0, 1, 12, 1, 12);
    chk("R8 store bypass", {1'b0, stb}, 2'b01);
    apply(2, 3, 0, 0, 0, 12, 1, 12);
    chk("R8 no store flag", {1'b0, stb}, 2'b00);
    apply(2, 3, 0, 0, 1, 13, 1, 12);
    chk("R8 rt mismatch", {1'b0, stb}, 2'b00);
    // Random mix
    for (int i = 0; i < 3000; i++) begin
      apply(pick_reg(), pick_reg(), 1'($urandom), pick_reg(), 1'($urandom),
            pick_reg(), 1'($urandom), pick_reg());
      check_all("rand");
      if (sa == 2'b11 || sb == 2'b11) chk("R1 code 11 seen", 2'b11, 2'b00);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule